// File: doc/BRIEF.md
# Automatic Thermal Sensor Monitor

This block watches up to four temperature sensor channels without software help. Once software has set the per-channel enables and then the global run bit, a small sequencer requests one conversion at a time from an external converter over a start/done handshake. It visits the enabled channels in ascending cyclic order and waits a programmable number of clock cycles between conversions. Each result is compared against a per-channel interrupt threshold and a per-channel shutdown threshold. A flag is raised only when a channel has read strictly above a threshold on several consecutive samples. The interrupt and shutdown thresholds each have their own debounce count.

While any enabled channel's latest reading is above either of its thresholds, the sequencer uses a second, shorter wait period. Interrupt and shutdown flags are sticky and are cleared by writing 1 to them. The interrupt output is the OR of the interrupt flags that are unmasked. Shutdown flags can be routed, per channel, to a clock/reset output and to a pin output, with two independent enables. A configuration bit sets the polarity of both shutdown outputs. A status field records which channel raised the most recent shutdown.

The sequencer has five states:
- IDLE: waiting for the run bit and at least one enable.
- LAUNCH: a one-cycle start pulse.
- BUSY: waiting for done.
- JUDGE: loads the wait period that the temperature state selects.
- GAP: counting the wait down.

Its transitions are:
- IDLE→LAUNCH when running with a channel enabled.
- LAUNCH→BUSY always.
- BUSY→JUDGE on done.
- JUDGE→GAP always.
- GAP→LAUNCH when the count is zero.
- GAP→IDLE when the run bit or all enables are cleared.

Top module: `thermal_watch`

## Requirements
- R1: After reset, irq, shut_to_clkrst, shut_to_pin and adc_start are 0 and the flags word (address 2) reads 0.
- R2: Conversions start only while the run bit (address 0 bit 0) is 1 and at least one channel enable (address 0 bits 4:1, bit 1 = channel 0) is set. Only enabled channels are requested, in ascending cyclic order, and order restarts from the lowest enabled channel after the sequencer returns to IDLE.
- R3: adc_start is a one-cycle pulse, and adc_chan holds its value until adc_done is accepted.
- R4: With no enabled channel hot, the next adc_start rises P+1 clock edges after the edge that accepts adc_done, where P is the normal period (address 3; 0 acts as 1).
- R5: When any enabled channel's latest reading is strictly above its interrupt or shutdown threshold, the fast period (address 4) is used in place of P.
- R6: A channel's interrupt flag (address 2 bit c) sets on the Nth consecutive sample strictly above its interrupt threshold (address 8+c), where N is the interrupt debounce (address 5; 0 acts as 1). A sample at or below the threshold resets the run to zero.
- R7: A channel's shutdown flag (address 2 bit 4+c) sets on the Mth consecutive sample strictly above its shutdown threshold (address 12+c), where M is the shutdown debounce (address 6), with its own run counter.
- R8: Flags stay set until 1 is written to their bit at address 2. irq is the OR of interrupt flags whose mask bit (address 1 bits 3:0) is 1.
- R9: shut_to_clkrst is the OR of shutdown flags enabled by address 1 bits 7:4, and shut_to_pin the OR of those enabled by address 1 bits 11:8. Both are inverted (active low) when address 0 bit 5 is 1.
- R10: Address 2 bits 9:8 hold the index of the channel whose shutdown flag was set most recently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| adc_start | output | 1 | Conversion request pulse |
| adc_chan | output | 2 | Channel being converted |
| adc_done | input | 1 | Conversion complete, adc_data valid |
| adc_data | input | 10 | Conversion result |
| irq | output | 1 | Interrupt request |
| shut_to_clkrst | output | 1 | Shutdown to clock/reset logic |
| shut_to_pin | output | 1 | Shutdown to pin |

## Verification
The hardest situation to reach is a debounce run that is broken by a single low reading. Channels are visited in alternation, so a specific sample of a specific channel must be steered while the other channel keeps running. The bench holds a per-channel temperature table that its converter model reads at each done. A task waits for a given number of completed samples of one channel before it changes that entry. This makes it possible to place the sequence high, high, low, high, high and then one more high precisely. The same model lets the bench predict, at every start, whether the fast or normal period applies.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_LAUNCH,
        ST_BUSY,
        ST_JUDGE
    } seq_state_t;

    localparam int unsigned ADDR_CTRL  = 0;
    localparam int unsigned ADDR_ROUTE = 1;
    localparam int unsigned ADDR_FLAGS = 2;
    localparam int unsigned ADDR_PNORM = 3;
    localparam int unsigned ADDR_PFAST = 4;
    localparam int unsigned ADDR_DIRQ  = 5;
    localparam int unsigned ADDR_DSHUT = 6;
    localparam int unsigned ADDR_TIRQ  = 8;
    localparam int unsigned ADDR_TSHUT = 12;
endpackage

// File: rtl/tw_regs.sv
module tw_regs
    import tw_pkg::*;
#(
    parameter int unsigned NCH       = 4,
    parameter int unsigned DW        = 10,
    parameter int unsigned PW        = 18,
    parameter int unsigned DBW       = 4,
    parameter int unsigned PNORM_RST = 187500,
    parameter int unsigned PFAST_RST = 37500,
    parameter int unsigned DEB_RST   = 4,
    localparam int unsigned CW       = $clog2(NCH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [4:0]              reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    input  logic [NCH-1:0]          irq_pend,
    input  logic [NCH-1:0]          shut_pend,
    input  logic [CW-1:0]           last_shut,
    output logic                    auto_go,
    output logic [NCH-1:0]          chan_en,
    output logic                    shut_inv,
    output logic [NCH-1:0]          irq_en,
    output logic [NCH-1:0]          clk_en,
    output logic [NCH-1:0]          pin_en,
    output logic [PW-1:0]           per_norm,
    output logic [PW-1:0]           per_fast,
    output logic [DBW-1:0]          deb_irq,
    output logic [DBW-1:0]          deb_shut,
    output logic [NCH-1:0][DW-1:0]  thr_irq,
    output logic [NCH-1:0][DW-1:0]  thr_shut,
    output logic [NCH-1:0]          clr_irq,
    output logic [NCH-1:0]          clr_shut
);
    logic unused_wdata;
    assign unused_wdata = ^reg_wdata[31:PW];

    logic wr_flags;
    assign wr_flags = reg_wr && (reg_addr == 5'(ADDR_FLAGS));
    assign clr_irq  = wr_flags ? reg_wdata[NCH-1:0] : '0;
    assign clr_shut = wr_flags ? reg_wdata[2*NCH-1:NCH] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_go  <= 1'b0;
            chan_en  <= '0;
            shut_inv <= 1'b0;
            irq_en   <= '0;
            clk_en   <= '0;
            pin_en   <= '0;
            per_norm <= PW'(PNORM_RST);
            per_fast <= PW'(PFAST_RST);
            deb_irq  <= DBW'(DEB_RST);
            deb_shut <= DBW'(DEB_RST);
            thr_irq  <= '1;
            thr_shut <= '1;
        end else if (reg_wr) begin
            if (reg_addr == 5'(ADDR_CTRL)) begin
                auto_go  <= reg_wdata[0];
                chan_en  <= reg_wdata[NCH:1];
                shut_inv <= reg_wdata[NCH+1];
            end
            if (reg_addr == 5'(ADDR_ROUTE)) begin
                irq_en <= reg_wdata[NCH-1:0];
                clk_en <= reg_wdata[2*NCH-1:NCH];
                pin_en <= reg_wdata[3*NCH-1:2*NCH];
            end
            if (reg_addr == 5'(ADDR_PNORM)) per_norm <= reg_wdata[PW-1:0];
            if (reg_addr == 5'(ADDR_PFAST)) per_fast <= reg_wdata[PW-1:0];
            if (reg_addr == 5'(ADDR_DIRQ))  deb_irq  <= reg_wdata[DBW-1:0];
            if (reg_addr == 5'(ADDR_DSHUT)) deb_shut <= reg_wdata[DBW-1:0];
            for (int c = 0; c < NCH; c++) begin
                if (reg_addr == 5'(ADDR_TIRQ + c))  thr_irq[c]  <= reg_wdata[DW-1:0];
                if (reg_addr == 5'(ADDR_TSHUT + c)) thr_shut[c] <= reg_wdata[DW-1:0];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == 5'(ADDR_CTRL))  reg_rdata[NCH+1:0]   = {shut_inv, chan_en, auto_go};
        if (reg_addr == 5'(ADDR_ROUTE)) reg_rdata[3*NCH-1:0] = {pin_en, clk_en, irq_en};
        if (reg_addr == 5'(ADDR_FLAGS)) reg_rdata[2*NCH+CW-1:0] = {last_shut, shut_pend, irq_pend};
        if (reg_addr == 5'(ADDR_PNORM)) reg_rdata[PW-1:0]    = per_norm;
        if (reg_addr == 5'(ADDR_PFAST)) reg_rdata[PW-1:0]    = per_fast;
        if (reg_addr == 5'(ADDR_DIRQ))  reg_rdata[DBW-1:0]   = deb_irq;
        if (reg_addr == 5'(ADDR_DSHUT)) reg_rdata[DBW-1:0]   = deb_shut;
        for (int c = 0; c < NCH; c++) begin
            if (reg_addr == 5'(ADDR_TIRQ + c))  reg_rdata[DW-1:0] = thr_irq[c];
            if (reg_addr == 5'(ADDR_TSHUT + c)) reg_rdata[DW-1:0] = thr_shut[c];
        end
    end
endmodule

// File: rtl/tw_chan.sv
module tw_chan #(
    parameter int unsigned DW  = 10,
    parameter int unsigned DBW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_vld,
    input  logic [DW-1:0]  smp_data,
    input  logic [DW-1:0]  thr_irq,
    input  logic [DW-1:0]  thr_shut,
    input  logic [DBW-1:0] deb_irq,
    input  logic [DBW-1:0] deb_shut,
    input  logic           clr_irq,
    input  logic           clr_shut,
    output logic           irq_pend,
    output logic           shut_pend,
    output logic           shut_hit,
    output logic           above
);
    logic [DBW-1:0] irq_run, shut_run;
    logic [DBW-1:0] goal_i, goal_s;
    logic [DBW:0]   nx_i, nx_s;
    logic           over_i, over_s, step_i, step_s;

    assign over_i = smp_data > thr_irq;
    assign over_s = smp_data > thr_shut;
    assign goal_i = (deb_irq == '0) ? DBW'(1) : deb_irq;
    assign goal_s = (deb_shut == '0) ? DBW'(1) : deb_shut;
    assign nx_i   = {1'b0, irq_run} + 1'b1;
    assign nx_s   = {1'b0, shut_run} + 1'b1;
    assign step_i = smp_vld && over_i && (nx_i >= {1'b0, goal_i});
    assign step_s = smp_vld && over_s && (nx_s >= {1'b0, goal_s});
    assign shut_hit = step_s && !shut_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_run   <= '0;
            shut_run  <= '0;
            irq_pend  <= 1'b0;
            shut_pend <= 1'b0;
            above     <= 1'b0;
        end else begin
            if (smp_vld) begin
                irq_run  <= !over_i ? '0 : ((&irq_run) ? irq_run : irq_run + 1'b1);
                shut_run <= !over_s ? '0 : ((&shut_run) ? shut_run : shut_run + 1'b1);
                above    <= over_i || over_s;
            end
            if (step_i)       irq_pend  <= 1'b1;
            else if (clr_irq) irq_pend  <= 1'b0;
            if (step_s)        shut_pend <= 1'b1;
            else if (clr_shut) shut_pend <= 1'b0;
        end
    end

    a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pend) |-> $past(smp_vld && (smp_data > thr_irq)));
    a_r7_shut_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shut_pend) |-> $past(smp_vld && (smp_data > thr_shut)));
    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend && !clr_irq) |=> irq_pend);
    a_r8_shut_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (shut_pend && !clr_shut) |=> shut_pend);
endmodule

// File: rtl/tw_seq.sv
module tw_seq
    import tw_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned PW  = 18,
    localparam int unsigned CW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           auto_go,
    input  logic [NCH-1:0] chan_en,
    input  logic           hot,
    input  logic [PW-1:0]  per_norm,
    input  logic [PW-1:0]  per_fast,
    input  logic           adc_done,
    output logic           adc_start,
    output logic [CW-1:0]  adc_chan,
    output logic           smp_vld
);
    seq_state_t     state, state_nx;
    logic [PW-1:0]  gap_cnt;
    logic [CW-1:0]  cur_ch;
    logic           runnable;

    assign runnable = auto_go && (chan_en != '0);

    function automatic logic [CW-1:0] pick(input logic [NCH-1:0] en, input logic [CW-1:0] from);
        logic [CW-1:0] r;
        logic [CW-1:0] idx;
        r = from;
        for (int k = NCH; k >= 1; k--) begin
            idx = CW'((int'(from) + k) % NCH);
            if (en[idx]) r = idx;
        end
        return r;
    endfunction

    function automatic logic [PW-1:0] span(input logic [PW-1:0] p);
        return (p == '0) ? '0 : p - 1'b1;
    endfunction

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (runnable) state_nx = ST_LAUNCH;
            ST_GAP:    if (!runnable) state_nx = ST_IDLE;
                       else if (gap_cnt == '0) state_nx = ST_LAUNCH;
            ST_LAUNCH: state_nx = ST_BUSY;
            ST_BUSY:   if (adc_done) state_nx = ST_JUDGE;
            ST_JUDGE:  state_nx = ST_GAP;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt <= '0;
            cur_ch  <= CW'(NCH - 1);
        end else begin
            if (state == ST_JUDGE)
                gap_cnt <= hot ? span(per_fast) : span(per_norm);
            else if (state == ST_GAP && gap_cnt != '0)
                gap_cnt <= gap_cnt - 1'b1;
            if (state_nx == ST_IDLE)
                cur_ch <= CW'(NCH - 1);
            else if (state_nx == ST_LAUNCH && state != ST_LAUNCH)
                cur_ch <= pick(chan_en, cur_ch);
        end
    end

    always_comb begin
        adc_start = (state == ST_LAUNCH);
        smp_vld   = (state == ST_BUSY) && adc_done;
        adc_chan  = cur_ch;
    end

    a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);
    a_r3_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY) |-> $stable(adc_chan));
    a_r2_start_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_start) |-> $past(auto_go));
    a_r4_no_early_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP && gap_cnt != '0) |=> (state != ST_LAUNCH));
endmodule

// File: rtl/thermal_watch.sv
module thermal_watch
    import tw_pkg::*;
#(
    parameter int unsigned NCH       = 4,
    parameter int unsigned DW        = 10,
    parameter int unsigned PW        = 18,
    parameter int unsigned DBW       = 4,
    parameter int unsigned PNORM_RST = 187500,
    parameter int unsigned PFAST_RST = 37500,
    parameter int unsigned DEB_RST   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic [4:0]                reg_addr,
    input  logic [31:0]               reg_wdata,
    output logic [31:0]               reg_rdata,
    output logic                      adc_start,
    output logic [$clog2(NCH)-1:0]    adc_chan,
    input  logic                      adc_done,
    input  logic [DW-1:0]             adc_data,
    output logic                      irq,
    output logic                      shut_to_clkrst,
    output logic                      shut_to_pin
);
    localparam int unsigned CW = $clog2(NCH);

    logic                   auto_go, shut_inv, hot, smp_vld;
    logic [NCH-1:0]         chan_en, irq_en, clk_en, pin_en;
    logic [NCH-1:0]         clr_irq, clr_shut, irq_pend, shut_pend, shut_hit, above;
    logic [PW-1:0]          per_norm, per_fast;
    logic [DBW-1:0]         deb_irq, deb_shut;
    logic [NCH-1:0][DW-1:0] thr_irq, thr_shut;
    logic [CW-1:0]          last_shut;

    tw_regs #(
        .NCH(NCH), .DW(DW), .PW(PW), .DBW(DBW),
        .PNORM_RST(PNORM_RST), .PFAST_RST(PFAST_RST), .DEB_RST(DEB_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_pend(irq_pend), .shut_pend(shut_pend), .last_shut(last_shut),
        .auto_go(auto_go), .chan_en(chan_en), .shut_inv(shut_inv),
        .irq_en(irq_en), .clk_en(clk_en), .pin_en(pin_en),
        .per_norm(per_norm), .per_fast(per_fast),
        .deb_irq(deb_irq), .deb_shut(deb_shut),
        .thr_irq(thr_irq), .thr_shut(thr_shut),
        .clr_irq(clr_irq), .clr_shut(clr_shut)
    );

    tw_seq #(.NCH(NCH), .PW(PW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .auto_go(auto_go), .chan_en(chan_en), .hot(hot),
        .per_norm(per_norm), .per_fast(per_fast),
        .adc_done(adc_done), .adc_start(adc_start), .adc_chan(adc_chan),
        .smp_vld(smp_vld)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tw_chan #(.DW(DW), .DBW(DBW)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .smp_vld(smp_vld && (adc_chan == CW'(c))),
            .smp_data(adc_data),
            .thr_irq(thr_irq[c]), .thr_shut(thr_shut[c]),
            .deb_irq(deb_irq), .deb_shut(deb_shut),
            .clr_irq(clr_irq[c]), .clr_shut(clr_shut[c]),
            .irq_pend(irq_pend[c]), .shut_pend(shut_pend[c]),
            .shut_hit(shut_hit[c]), .above(above[c])
        );

        a_r10_last_tracks: assert property (@(posedge clk) disable iff (!rst_n)
            shut_hit[c] |=> (last_shut == CW'(c)));
    end

    assign hot = |(above & chan_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_shut <= '0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (shut_hit[c]) last_shut <= CW'(c);
            end
        end
    end

    assign irq            = |(irq_pend & irq_en);
    assign shut_to_clkrst = (|(shut_pend & clk_en)) ^ shut_inv;
    assign shut_to_pin    = (|(shut_pend & pin_en)) ^ shut_inv;

    a_r9_clk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((shut_pend & clk_en) == '0) |-> (shut_to_clkrst == shut_inv));
endmodule

// File: tb/sim_thermal_watch.sv
module sim_thermal_watch;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        adc_start;
    logic [1:0]  adc_chan;
    logic        adc_done = 1'b0;
    logic [9:0]  adc_data = '0;
    logic        irq, shut_to_clkrst, shut_to_pin;

    always #4 clk = ~clk;

    thermal_watch u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .adc_start(adc_start), .adc_chan(adc_chan), .adc_done(adc_done), .adc_data(adc_data),
        .irq(irq), .shut_to_clkrst(shut_to_clkrst), .shut_to_pin(shut_to_pin)
    );

    int     checks = 0;
    int     fails = 0;
    longint cyc = 0;
    int     temp[NCH];
    int     last[NCH];
    int     n_done[NCH];
    int     n_start = 0;
    int     sb[$];
    logic [3:0] mask_b = '0;
    int     pnorm = 20;
    int     pfast = 5;
    int     thr_i = 500;
    int     thr_s = 677;
    longint done_cyc = 0;
    bit     done_ok = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit bench_hot();
        bit h = 0;
        for (int c = 0; c < NCH; c++)
            if (mask_b[c] && (last[c] > thr_i || last[c] > thr_s)) h = 1;
        return h;
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = 32'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 5'(a);
        #1 d = reg_rdata;
    endtask

    task automatic push_pair(input int a, input int b, input int n);
        repeat (n) begin
            sb.push_back(a);
            sb.push_back(b);
        end
    endtask

    task automatic wait_sample(input int ch, input int n);
        int target;
        target = n_done[ch] + n;
        while (n_done[ch] < target) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // converter model and scoreboard monitor
    initial begin
        for (int c = 0; c < NCH; c++) begin
            temp[c] = 300; last[c] = 0; n_done[c] = 0;
        end
        forever begin
            @(negedge clk);
            if (adc_start) begin
                int ch;
                int p;
                bit h;
                ch = int'(adc_chan);
                n_start++;
                if (sb.size() == 0) begin
                    chk(0, "R2 unexpected start", ch, -1);
                end else begin
                    int e;
                    e = sb.pop_front();
                    chk(ch == e, "R2 channel order", ch, e);
                end
                if (done_ok) begin
                    h = bench_hot();
                    p = h ? pfast : pnorm;
                    if (h) chk(cyc - done_cyc == longint'(p + 2), "R5 fast interval", cyc - done_cyc, p + 2);
                    else   chk(cyc - done_cyc == longint'(p + 2), "R4 normal interval", cyc - done_cyc, p + 2);
                end
                @(negedge clk);
                chk(adc_start == 1'b0, "R3 start pulse width", adc_start, 0);
                repeat (2) @(negedge clk);
                chk(int'(adc_chan) == ch, "R3 channel held", adc_chan, ch);
                adc_data = 10'(temp[ch]);
                adc_done = 1'b1;
                last[ch] = temp[ch];
                done_cyc = cyc;
                done_ok = 1;
                n_done[ch]++;
                @(negedge clk);
                adc_done = 1'b0;
            end
        end
    end

    task automatic run();
        logic [31:0] d;
        int snap;
        repeat (5) @(negedge clk);
        chk(irq == 1'b0, "R1 irq reset", irq, 0);
        chk(shut_to_clkrst == 1'b0, "R1 clkrst reset", shut_to_clkrst, 0);
        chk(shut_to_pin == 1'b0, "R1 pin reset", shut_to_pin, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(n_start == 0, "R1 no start after reset", n_start, 0);
        rd(2, d);
        chk(d == 0, "R1 flags reset", d, 0);

        wr(3, pnorm);
        wr(4, pfast);
        wr(5, 3);
        wr(6, 2);
        for (int c = 0; c < NCH; c++) begin
            wr(8 + c, thr_i);
            wr(12 + c, thr_s);
        end
        wr(1, 32'h41F);            // irq mask all, ch0 to clk/reset, ch2 to pin
        mask_b = 4'b0101;
        wr(0, 32'h0A);             // ch0 and ch2 enabled, run bit low
        repeat (60) @(negedge clk);
        chk(n_start == 0, "R2 no start without run bit", n_start, 0);

        push_pair(0, 2, 200);
        done_ok = 0;
        wr(0, 32'h0B);
        wait_sample(2, 3);

        // R6 debounce with a broken run
        temp[0] = 600; wait_sample(0, 2);
        temp[0] = 400; wait_sample(0, 1);
        temp[0] = 600; wait_sample(0, 2);
        rd(2, d);
        chk(d[0] == 1'b0, "R6 low sample resets run", d[0], 0);
        chk(irq == 1'b0, "R6 irq held off", irq, 0);
        wait_sample(0, 1);
        rd(2, d);
        chk(d[0] == 1'b1, "R6 flag on third high", d[0], 1);
        chk(irq == 1'b1, "R6 irq raised", irq, 1);

        // R8 sticky and write-1-to-clear
        temp[0] = 300; wait_sample(0, 2);
        rd(2, d);
        chk(d[0] == 1'b1, "R8 flag sticky", d[0], 1);
        wr(2, 32'h1);
        rd(2, d);
        chk(d[3:0] == 4'h0, "R8 flag cleared", d[3:0], 0);
        chk(irq == 1'b0, "R8 irq cleared", irq, 0);

        // R7 shutdown debounce and R9 routing
        temp[2] = 700; wait_sample(2, 1);
        rd(2, d);
        chk(d[6] == 1'b0, "R7 no shutdown after one", d[6], 0);
        chk(shut_to_pin == 1'b0, "R9 pin idle", shut_to_pin, 0);
        wait_sample(2, 1);
        rd(2, d);
        chk(d[6] == 1'b1, "R7 shutdown on second", d[6], 1);
        chk(d[9:8] == 2'd2, "R10 last is ch2", d[9:8], 2);
        chk(shut_to_pin == 1'b1, "R9 pin routed", shut_to_pin, 1);
        chk(shut_to_clkrst == 1'b0, "R9 clk not routed", shut_to_clkrst, 0);
        wr(1, 32'h411);            // only ch0 interrupt unmasked
        wait_sample(2, 1);
        rd(2, d);
        chk(d[2] == 1'b1, "R8 ch2 irq flag set", d[2], 1);
        chk(irq == 1'b0, "R8 masked flag no irq", irq, 0);

        wr(0, 32'h2B);             // invert shutdown polarity
        chk(shut_to_clkrst == 1'b1, "R9 clk inverted idle", shut_to_clkrst, 1);
        chk(shut_to_pin == 1'b0, "R9 pin inverted active", shut_to_pin, 0);

        temp[2] = 300; temp[0] = 700;
        wait_sample(0, 2);
        rd(2, d);
        chk(d[4] == 1'b1, "R7 ch0 shutdown", d[4], 1);
        chk(d[9:8] == 2'd0, "R10 last is ch0", d[9:8], 0);
        chk(shut_to_clkrst == 1'b0, "R9 clk active low", shut_to_clkrst, 0);

        temp[0] = 300; wait_sample(0, 1);
        wr(2, 32'hF0);
        rd(2, d);
        chk(d[7:4] == 4'h0, "R8 shutdown flags cleared", d[7:4], 0);
        chk(d[3:0] == 4'h4, "R8 irq flags untouched", d[3:0], 4);
        chk(shut_to_clkrst == 1'b1, "R9 clk released", shut_to_clkrst, 1);
        chk(shut_to_pin == 1'b1, "R9 pin released", shut_to_pin, 1);

        // R2 stop, restart with another channel set
        wr(0, 32'h20);
        mask_b = 4'b0000;
        repeat (100) @(negedge clk);
        snap = n_start;
        repeat (100) @(negedge clk);
        chk(n_start == snap, "R2 stopped", n_start, snap);
        sb.delete();
        push_pair(1, 3, 100);
        done_ok = 0;
        mask_b = 4'b1010;
        wr(0, 32'h35);
        wait_sample(3, 3);

        // R2 running with no channel enabled
        wr(0, 32'h21);
        mask_b = 4'b0000;
        repeat (40) @(negedge clk);
        snap = n_start;
        repeat (60) @(negedge clk);
        chk(n_start == snap, "R2 no start with no enables", n_start, snap);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (150000) @(posedge clk);
                chk(0, "watchdog expired", 0, 1);
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule